// File: doc/BRIEF.md
# Add-Only Memory Read Engine with CRC

This block answers read requests from a byte-serial master for a 128-byte memory that is split into four 32-byte pages. The master first sends a command byte and then a 16-bit start address, low byte first. The engine replies with an 8-bit CRC of those three bytes, so the master can confirm that they arrived intact. After that, it returns memory bytes one at a time, each time the master asks for one.

Two read modes are available. In the end-of-memory mode, the engine sends every byte from the start address to the last byte of memory, followed by one CRC computed over the data bytes only. In the per-page mode, a CRC follows the last byte of every page. The CRC register restarts after each page CRC, so only the first page's CRC also covers the command and address bytes.

Once the last CRC has gone out, every further request returns FFh. A bus reset on `abortIn` returns the engine at once to waiting for a new command. A read that a bus reset cuts short never sends its data CRC. The memory is read through a synchronous port with one cycle of latency.

Top module: `aom_read_engine`

## Requirements
- R1: After the command byte and the address low and high bytes are received, the first response is the CRC-8 over those three bytes in that order. The polynomial is x^8+x^5+x^4+1, processed least significant bit first (reflected constant 8Ch), with the register starting at 00h.
- R2: Command F0h selects the end-of-memory mode. Each request then returns the memory byte at the current address, starting at the start address and rising by one up to address 127.
- R3: In the end-of-memory mode, the request after the byte at address 127 returns the CRC-8 over all data bytes sent (register restarted at 00h after the header CRC).
- R4: After the final CRC of a read, every request returns FFh until `abortIn`.
- R5: While `abortIn` is high for one cycle, the engine returns to waiting for a command and restarts its CRC at 00h. A request issued before a new command gets no response, so an aborted read never sends its data CRC.
- R6: Command C3h selects the per-page mode. After each data byte at an address whose low 5 bits are all ones, the next request returns a CRC, and the CRC register then restarts at 00h. The first CRC covers the command, the address bytes and the data. The CRC after address 127 is the final one.
- R7: If the 16-bit start address is 128 or more, every request after the header CRC returns FFh.
- R8: Any other command byte causes the following address bytes to be ignored, and every request returns FFh until `abortIn`.
- R9: A request sampled at clock edge t drives `memRdEn` together with `memAddr` in the cycle before t when a data byte is due. It produces a one-cycle `txValid` pulse, with the byte on `txData`, after edge t+1. A request in the command or address phase produces no pulse.
- R10: While `rstN` is low and right after it rises, `txValid` and `memRdEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| abortIn | input | 1 | Bus reset: abort the current transaction |
| rxValid | input | 1 | One-cycle strobe: a byte from the master is on rxData |
| rxData | input | 8 | Byte received from the master |
| txReq | input | 1 | One-cycle strobe: the master asks for the next byte |
| txValid | output | 1 | One-cycle strobe: the response byte is on txData |
| txData | output | 8 | Response byte |
| memRdEn | output | 1 | Memory read enable |
| memAddr | output | 7 | Memory byte address |
| memRdData | input | 8 | Memory read data, valid one cycle after memRdEn |

## Verification
A received byte takes effect at the edge where `rxValid` is sampled. A request sampled at edge t is due on `txValid`/`txData` after edge t+1, and the memory strobe it causes is visible before edge t. The bench therefore drives each request before one edge. It checks the memory strobe and address before that edge, checks after it that no pulse has come out yet, and reads the byte one edge later. The expected stream comes from a behavioural queue model built from the memory contents and the mode. Each request is spaced several cycles from the next, and a request after an abort must leave `txValid` low through the cycle in which a byte would have been due.

// File: rtl/aom_read_pkg.sv
package aom_read_pkg;

  typedef enum logic [1:0] {
    SEND_NONE,
    SEND_CRC,
    SEND_MEM,
    SEND_ONES
  } sendKind_t;

  typedef struct packed {
    logic      abort;
    logic      rxToCrc;
    logic      loadLo;
    logic      loadHi;
    logic      incAddr;
    sendKind_t send;
    logic      clrAfter;
  } ctlStrobes_t;

  function automatic logic [7:0] crc8Step(input logic [7:0] crcIn, input logic [7:0] dIn);
    logic [7:0] c;
    c = crcIn;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ dIn[i]) c = (c >> 1) ^ 8'h8C;
      else               c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/aom_read_ctrl.sv
module aom_read_ctrl
  import aom_read_pkg::*;
#(
  parameter int MEM_BYTES  = 128,
  parameter int PAGE_BYTES = 32,
  parameter logic [7:0] CMD_ALL  = 8'hF0,
  parameter logic [7:0] CMD_PAGE = 8'hC3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        abortIn,
  input  logic        rxValid,
  input  logic [7:0]  rxData,
  input  logic        txReq,
  input  logic [15:0] addrQ,
  output ctlStrobes_t ctl,
  output logic        memRdEn
);
  localparam int PAGE_AW = $clog2(PAGE_BYTES);

  typedef enum logic [2:0] {S_CMD, S_ALO, S_AHI, S_HCRC, S_DATA, S_DCRC, S_DONE} state_t;
  state_t state, stateNext;
  logic   modePage;
  logic   lastByte, pageEnd, outOfRange;

  assign lastByte   = (addrQ == 16'(MEM_BYTES - 1));
  assign pageEnd    = (addrQ[PAGE_AW-1:0] == {PAGE_AW{1'b1}});
  assign outOfRange = (addrQ >= 16'(MEM_BYTES));

  always_comb begin
    ctl       = '0;
    ctl.send  = SEND_NONE;
    stateNext = state;
    if (abortIn) begin
      ctl.abort = 1'b1;
      stateNext = S_CMD;
    end else begin
      case (state)
        S_CMD: if (rxValid) begin
          ctl.rxToCrc = 1'b1;
          stateNext   = (rxData == CMD_ALL || rxData == CMD_PAGE) ? S_ALO : S_DONE;
        end
        S_ALO: if (rxValid) begin
          ctl.rxToCrc = 1'b1;
          ctl.loadLo  = 1'b1;
          stateNext   = S_AHI;
        end
        S_AHI: if (rxValid) begin
          ctl.rxToCrc = 1'b1;
          ctl.loadHi  = 1'b1;
          stateNext   = S_HCRC;
        end
        S_HCRC: if (txReq) begin
          ctl.send     = SEND_CRC;
          ctl.clrAfter = !modePage;
          stateNext    = outOfRange ? S_DONE : S_DATA;
        end
        S_DATA: if (txReq) begin
          ctl.send    = SEND_MEM;
          ctl.incAddr = 1'b1;
          if (lastByte || (modePage && pageEnd)) stateNext = S_DCRC;
        end
        S_DCRC: if (txReq) begin
          ctl.send     = SEND_CRC;
          ctl.clrAfter = 1'b1;
          stateNext    = (modePage && !outOfRange) ? S_DATA : S_DONE;
        end
        default: if (txReq) ctl.send = SEND_ONES;
      endcase
    end
  end

  assign memRdEn = (ctl.send == SEND_MEM);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_CMD;
      modePage <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == S_CMD && rxValid && !abortIn) modePage <= (rxData == CMD_PAGE);
    end
  end

  // R5
  abort_to_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortIn |=> state == S_CMD);

  // R4
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DONE && !abortIn) |=> state == S_DONE);

  // R6
  page_end_crc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modePage && memRdEn && pageEnd) |=> state == S_DCRC);

endmodule

// File: rtl/aom_read_dpath.sv
module aom_read_dpath
  import aom_read_pkg::*;
#(
  parameter int MEM_BYTES = 128,
  localparam int MEM_AW   = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [7:0]        rxData,
  input  logic [7:0]        memRdData,
  output logic [15:0]       addrQ,
  output logic [MEM_AW-1:0] memAddr,
  output logic              txValid,
  output logic [7:0]        txData
);
  logic [7:0] crcQ;
  sendKind_t  pendKind;
  logic       pendClr;

  assign memAddr = addrQ[MEM_AW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      crcQ     <= '0;
      pendKind <= SEND_NONE;
      pendClr  <= 1'b0;
      txValid  <= 1'b0;
      txData   <= '0;
    end else if (ctl.abort) begin
      crcQ     <= '0;
      pendKind <= SEND_NONE;
      pendClr  <= 1'b0;
      txValid  <= 1'b0;
    end else begin
      pendKind <= ctl.send;
      pendClr  <= ctl.clrAfter;
      txValid  <= (pendKind != SEND_NONE);
      if (ctl.loadLo)  addrQ[7:0]  <= rxData;
      if (ctl.loadHi)  addrQ[15:8] <= rxData;
      if (ctl.incAddr) addrQ       <= addrQ + 16'd1;
      if (ctl.rxToCrc) crcQ        <= crc8Step(crcQ, rxData);
      case (pendKind)
        SEND_CRC: begin
          txData <= crcQ;
          if (pendClr) crcQ <= '0;
        end
        SEND_MEM: begin
          txData <= memRdData;
          crcQ   <= crc8Step(crcQ, memRdData);
        end
        SEND_ONES: txData <= 8'hFF;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/aom_read_engine.sv
module aom_read_engine
  import aom_read_pkg::*;
#(
  parameter int MEM_BYTES  = 128,
  parameter int PAGE_BYTES = 32,
  parameter logic [7:0] CMD_ALL  = 8'hF0,
  parameter logic [7:0] CMD_PAGE = 8'hC3,
  localparam int MEM_AW    = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              abortIn,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              txReq,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic              memRdEn,
  output logic [MEM_AW-1:0] memAddr,
  input  logic [7:0]        memRdData
);
  ctlStrobes_t ctl;
  logic [15:0] addrQ;

  aom_read_ctrl #(
    .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES),
    .CMD_ALL(CMD_ALL), .CMD_PAGE(CMD_PAGE)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .abortIn(abortIn), .rxValid(rxValid),
    .rxData(rxData), .txReq(txReq), .addrQ(addrQ), .ctl(ctl), .memRdEn(memRdEn)
  );

  aom_read_dpath #(.MEM_BYTES(MEM_BYTES)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxData(rxData), .memRdData(memRdData),
    .addrQ(addrQ), .memAddr(memAddr), .txValid(txValid), .txData(txData)
  );

  // R9
  tx_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(txReq, 2));

endmodule

// File: tb/aom_read_engine_tb_top.sv
module aom_read_engine_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       abortIn = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = '0;
  logic       txReq = 1'b0;
  logic       txValid;
  logic [7:0] txData;
  logic       memRdEn;
  logic [6:0] memAddr;
  logic [7:0] memRdData;

  logic [7:0] memArr [128];
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  int         addrQ[$];

  always #4 clk = ~clk;

  aom_read_engine dut_i (
    .clk(clk), .rstN(rstN), .abortIn(abortIn), .rxValid(rxValid), .rxData(rxData),
    .txReq(txReq), .txValid(txValid), .txData(txData), .memRdEn(memRdEn),
    .memAddr(memAddr), .memRdData(memRdData)
  );

  always @(posedge clk) if (memRdEn) memRdData <= memArr[memAddr];

  function automatic logic [7:0] refCrc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 8'h8C;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); rxValid = 1'b1; rxData = b;
    @(negedge clk); rxValid = 1'b0;
  endtask

  task automatic pulseAbort();
    @(negedge clk); abortIn = 1'b1;
    @(negedge clk); abortIn = 1'b0;
  endtask

  task automatic push(input logic [7:0] v, input string t, input int a);
    expQ.push_back(v); tagQ.push_back(t); addrQ.push_back(a);
  endtask

  task automatic buildExp(input logic [7:0] cmd, input logic [7:0] lo, input logic [7:0] hi, input int nOnes);
    logic [7:0] c = 8'h00;
    int a = int'({hi, lo});
    expQ.delete(); tagQ.delete(); addrQ.delete();
    if (cmd != 8'hF0 && cmd != 8'hC3) begin
      for (int k = 0; k < nOnes; k++) push(8'hFF, "R8 unknown command", -1);
      return;
    end
    c = refCrc(c, cmd); c = refCrc(c, lo); c = refCrc(c, hi);
    push(c, "R1 header crc", -1);
    if (cmd == 8'hF0) c = 8'h00;
    if (a >= 128) begin
      for (int k = 0; k < nOnes; k++) push(8'hFF, "R7 out of range", -1);
      return;
    end
    for (int i = a; i < 128; i++) begin
      push(memArr[i], (cmd == 8'hF0) ? "R2 data" : "R6 page data", i);
      c = refCrc(c, memArr[i]);
      if (cmd == 8'hC3 && (i % 32) == 31) begin
        push(c, "R6 page crc", -1);
        c = 8'h00;
      end
    end
    if (cmd == 8'hF0) push(c, "R3 end crc", -1);
    for (int k = 0; k < nOnes; k++) push(8'hFF, "R4 ones after crc", -1);
  endtask

  task automatic doReq(input logic [7:0] expv, input string tag, input int ea);
    @(negedge clk); txReq = 1'b1;
    #1;
    if (ea >= 0)
      check(memRdEn && memAddr == 7'(ea), {"R9 mem strobe ", tag}, int'(memAddr), ea);
    @(negedge clk); txReq = 1'b0;
    check(!txValid, {"R9 no early pulse ", tag}, int'(txValid), 0);
    @(negedge clk);
    check(txValid && txData == expv, tag, int'(txData), int'(expv));
    @(negedge clk);
    check(!txValid, {"R9 one cycle pulse ", tag}, int'(txValid), 0);
  endtask

  task automatic runReads(input int n);
    for (int k = 0; k < n && expQ.size() > 0; k++)
      doReq(expQ.pop_front(), tagQ.pop_front(), addrQ.pop_front());
  endtask

  task automatic transaction(input logic [7:0] cmd, input logic [7:0] lo, input logic [7:0] hi, input int nOnes);
    sendByte(cmd); sendByte(lo); sendByte(hi);
    buildExp(cmd, lo, hi, nOnes);
    runReads(expQ.size());
    pulseAbort();
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) memArr[i] = 8'((i * 37 + 5) & 255);
    repeat (3) @(negedge clk);
    check(!txValid && !memRdEn, "R10 reset outputs", int'({txValid, memRdEn}), 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(!txValid && !memRdEn, "R10 after reset", int'({txValid, memRdEn}), 0);

    transaction(8'hF0, 8'h7C, 8'h00, 2);
    transaction(8'hF0, 8'h00, 8'h00, 1);
    transaction(8'hC3, 8'h1E, 8'h00, 2);
    transaction(8'hC3, 8'h00, 8'h00, 1);
    transaction(8'hF0, 8'h80, 8'h00, 2);
    transaction(8'hC3, 8'h05, 8'h01, 2);
    transaction(8'h55, 8'h10, 8'h00, 3);

    sendByte(8'hF0); sendByte(8'h0A); sendByte(8'h00);
    buildExp(8'hF0, 8'h0A, 8'h00, 0);
    runReads(4);
    pulseAbort();
    @(negedge clk); txReq = 1'b1;
    @(negedge clk); txReq = 1'b0;
    @(negedge clk);
    check(!txValid, "R5 no response after abort", int'(txValid), 0);
    @(negedge clk);
    check(!txValid, "R5 no late response", int'(txValid), 0);
    transaction(8'hC3, 8'h5E, 8'h00, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule